// File: doc/BRIEF.md
# Six-Bit Bidirectional GPIO Port

This block is a six-pin general-purpose I/O port that sits on a small byte-wide register bus. It holds two registers: an output latch and a per-pin direction register. The direction bits drive the output-enable of tri-state pad buffers and the latch bits drive the pad output values. The pad input levels are sampled through a two-flop synchronizer.

Reading the data address returns a per-bit mix. Pins set as outputs return their latch bit, and pins set as inputs return their synchronized pad level. The latch accepts writes whatever the direction bits are. Software can therefore load the value a pin should drive before it turns that pin into an output, and the pin drives that value from its first cycle as an output. Only six of the eight bus bits exist: the two upper bits read as zero and ignore writes.

There is no state machine. The only sequential state is the two registers and the synchronizer chain, so the block has no named states or transitions.

Top module: `gpio6_port`

## Requirements
- R1: While reset is asserted and right after it, pad_oe and pad_out are 0, the direction register reads 0x00, and every pin acts as an input.
- R2: A write with bus_wr high to address 0x0C loads bus_wdata[5:0] into the direction register at that clock edge. pad_oe shows the new value after the edge, and a read at 0x0C returns it in bits 5:0.
- R3: A write with bus_wr high to address 0x08 loads bus_wdata[5:0] into the output latch at that clock edge, whatever the direction bits are. pad_out shows the new value after the edge.
- R4: A read at address 0x08 returns the latch bit for every pin whose direction bit is 1, even when the pad level differs.
- R5: A read at address 0x08 returns the synchronized pad level for every pin whose direction bit is 0. A pad change is visible after the second rising clock edge that follows it. A latch write to an input pin's bit does not change the value read for that pin.
- R6: Bits 7:6 of bus_rdata are always 0, and the bus_wdata[7:6] part of any write has no effect.
- R7: A read at any address other than 0x08 and 0x0C returns 0x00, and a write to such an address changes neither register.
- R8: When a direction bit goes from 0 to 1, pad_out for that pin already holds the latch value in the same cycle that pad_oe rises.
- R9: With bus_wr low, pad_out and pad_oe hold their values whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 6 | Asynchronous pad input levels |
| pad_out | output | 6 | Value driven toward the pad buffers |
| pad_oe | output | 6 | Pad output-enable, 1 = drive |

## Verification
Register writes show on pad_out, pad_oe and the read data one edge after the strobe. Read data is combinational from the address, so it is due in the same cycle. A change on pad_in reaches the data read only after two rising edges. The bench therefore drives every input on the falling edge and samples the results just before the following rising edge. For pad changes it samples after the first edge, where the old level is expected, and again after the second edge, where the new level is expected. This shows that both synchronizer stages are in the path and that neither one is bypassed.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio6_decode.sv
module gpio6_decode
    import gpio6_pkg::*;
#(
    parameter int               AW        = ADDR_W,
    parameter logic [AW-1:0]    DATA_ADDR = 'h08,
    parameter logic [AW-1:0]    DIR_ADDR  = 'h0C
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    always_comb begin
        if (addr == DATA_ADDR)
            sel = SEL_DATA;
        else if (addr == DIR_ADDR)
            sel = SEL_DIR;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio6_regs.sv
module gpio6_regs
    import gpio6_pkg::*;
#(
    parameter int PORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr && sel == SEL_DATA) begin
            latch_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr && sel == SEL_DIR) begin
            dir_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
    parameter int PORT_W = 6,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout
);
    logic [STAGES-1:0][PORT_W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain[0] <= '0;
        else
            chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain[s] <= '0;
            else
                chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio6_rdmux.sv
module gpio6_rdmux
    import gpio6_pkg::*;
#(
    parameter int PORT_W = 6,
    parameter int DW     = BUS_W
) (
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [DW-1:0]     rdata
);
    logic [PORT_W-1:0] data_view;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        assign data_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_DATA: rdata[PORT_W-1:0] = data_view;
            SEL_DIR:  rdata[PORT_W-1:0] = dir_q;
            SEL_NONE: rdata = '0;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int            PORT_W      = 6,
    parameter int            SYNC_STAGES = 2,
    parameter logic [7:0]    DATA_ADDR   = 8'h08,
    parameter logic [7:0]    DIR_ADDR    = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    localparam int SPARE_W = BUS_W - PORT_W;

    reg_sel_e          sel;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_sync;

    if (SPARE_W > 0) begin : g_spare
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[BUS_W-1:PORT_W];
    end

    gpio6_decode #(
        .AW        (ADDR_W),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio6_regs #(
        .PORT_W (PORT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata[PORT_W-1:0]),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio6_sync #(
        .PORT_W (PORT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    gpio6_rdmux #(
        .PORT_W (PORT_W),
        .DW     (BUS_W)
    ) u_rdmux (
        .sel      (sel),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
    parameter int         PORT_W    = 6,
    parameter logic [7:0] DATA_ADDR = 8'h08,
    parameter logic [7:0] DIR_ADDR  = 8'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe
);
    logic hit_data;
    logic hit_dir;
    assign hit_data = (bus_addr == DATA_ADDR);
    assign hit_dir  = (bus_addr == DIR_ADDR);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (pad_oe == '0 && pad_out == '0)
                else $error("pads not cleared in reset");
        end
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dir) |=> (pad_oe == $past(bus_wdata[PORT_W-1:0])));

    assert_dir_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dir |-> (bus_rdata[PORT_W-1:0] == pad_oe));

    assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_data) |=> (pad_out == $past(bus_wdata[PORT_W-1:0])));

    assert_out_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_data |-> ((bus_rdata[PORT_W-1:0] & pad_oe) == (pad_out & pad_oe)));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:PORT_W] == '0);

    assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_data && !hit_dir) |-> (bus_rdata == 8'h00));

    assert_oe_rise_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dir && !hit_data) |=> (pad_out == $past(pad_out)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (hit_data || hit_dir)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio6_port gpio6_port_chk #(
    .PORT_W    (PORT_W),
    .DATA_ADDR (DATA_ADDR),
    .DIR_ADDR  (DIR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio6_port_bench.sv
`timescale 1ns/1ps
module gpio6_port_bench;
    localparam int PW = 6;

    typedef enum int { K_RDATA, K_OUT, K_OE } kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [PW-1:0] pad_in = '0;
    logic [PW-1:0] pad_out;
    logic [PW-1:0] pad_oe;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    gpio6_port u_gpio6_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // monitor: pops the expected item and compares with the live output
    initial begin
        forever begin
            @(mon_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_OUT:   act = {2'b00, pad_out};
                    default: act = {2'b00, pad_oe};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(kind_e k, logic [7:0] e, string r);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.req  = r;
        sb_q.push_back(it);
        -> mon_ev;
        #1.5;
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_expect(logic [7:0] a, logic [7:0] e, string r);
        bus_addr = a;
        expect_item(K_RDATA, e, r);
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        edges(3);
        // R1: reset state on the pads
        expect_item(K_OE,  8'h00, "R1");
        expect_item(K_OUT, 8'h00, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        edges(2);
        read_expect(8'h0C, 8'h00, "R1");
        read_expect(8'h08, 8'h00, "R1");

        // R2 and R6: direction write with upper bits set
        bus_write(8'h0C, 8'hFF);
        expect_item(K_OE, 8'h3F, "R2");
        read_expect(8'h0C, 8'h3F, "R6");

        // R3 and R4: latch write, all pins outputs
        bus_write(8'h08, 8'hEA);
        expect_item(K_OUT, 8'h2A, "R3");
        read_expect(8'h08, 8'h2A, "R4");

        // R5: bits 5:4 as inputs, two-edge pad latency
        bus_write(8'h0C, 8'h0F);
        expect_item(K_OE, 8'h0F, "R2");
        pad_in = 6'h30;
        @(negedge clk);
        read_expect(8'h08, 8'h0A, "R5");
        @(negedge clk);
        read_expect(8'h08, 8'h3A, "R5");

        // R5 and R3: latch write to input bits does not change readback
        bus_write(8'h08, 8'h00);
        expect_item(K_OUT, 8'h00, "R3");
        read_expect(8'h08, 8'h30, "R5");

        // R8: preload latch while input, then enable the driver
        bus_write(8'h08, 8'h30);
        expect_item(K_OUT, 8'h30, "R3");
        expect_item(K_OE,  8'h0F, "R8");
        bus_write(8'h0C, 8'h3F);
        expect_item(K_OE,  8'h3F, "R8");
        expect_item(K_OUT, 8'h30, "R8");

        // R4: outputs ignore a differing pad level
        pad_in = 6'h00;
        edges(3);
        read_expect(8'h08, 8'h30, "R4");

        // R7: unmapped reads and writes
        read_expect(8'h09, 8'h00, "R7");
        read_expect(8'h00, 8'h00, "R7");
        read_expect(8'hFF, 8'h00, "R7");
        bus_write(8'h09, 8'h00);
        expect_item(K_OUT, 8'h30, "R7");
        expect_item(K_OE,  8'h3F, "R7");

        // R9: no strobe, no change
        bus_addr  = 8'h08;
        bus_wdata = 8'h15;
        edges(2);
        expect_item(K_OUT, 8'h30, "R9");
        bus_addr = 8'h0C;
        edges(2);
        expect_item(K_OE, 8'h3F, "R9");

        // R5: all inputs again, pad pattern visible after two edges
        bus_write(8'h0C, 8'h00);
        expect_item(K_OE, 8'h00, "R2");
        pad_in = 6'h2D;
        @(negedge clk);
        read_expect(8'h08, 8'h00, "R5");
        @(negedge clk);
        read_expect(8'h08, 8'h2D, "R5");
        read_expect(8'h0C, 8'h00, "R6");

        edges(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule